// File: doc/BRIEF.md
# Overcurrent and Short-Circuit Error Monitor

This block sits behind the error-detection filters of a multi-channel delta-sigma front end. It watches each channel's filtered result and each channel's raw one-bit modulator stream, and it keeps latched error flags. Each channel's result is checked against an upper and a lower limit and against a notification window. The sum of a chosen group of channels is checked against its own pair of thresholds. Long runs of identical bits on a data input are reported as a short circuit.

A level interrupt stays high while any overcurrent, sum or short-circuit flag is set. Window flags never raise it. Software reads the flags and then pulses a clear strobe. Detection is disarmed whenever the channels stop running, and it is rearmed only by an explicit arm pulse once the filters have settled.

Each channel delivers results on a valid/ready stream. The monitor never applies back-pressure: every `res_ready` bit is held high, and a result is consumed in the cycle its valid bit is high. The limits, thresholds and group select are plain control pins and are expected to stay stable while detection is armed.

Top module: `ocsc_guard`

## Requirements
- R1: While armed, a result on channel i with its valid bit high sets `oc_flag[i]` if the result is strictly above that channel's upper limit or strictly below its lower limit. Values equal to a limit set nothing. All values are unsigned.
- R2: While armed, a valid result with lower window bound ≤ result ≤ upper window bound sets `win_flag[i]`. The bounds are inclusive. A window flag alone never asserts `err_irq`.
- R3: `sum_grp` selects the summed channels with this encoding: 0 = {0,1,2}, 1 = {0,1}, 2 = {0}, 3 = {1}, 4 = {2}, and 5 to 7 = no channel. The unsigned sum sets `sum_hi_flag` when it is greater than `sum_hi_lim` and `sum_hi_en` is 1. It sets `sum_lo_flag` when it is less than `sum_lo_lim` and `sum_lo_en` is 1.
- R4: The sum is compared only in a cycle in which every selected channel has its valid bit high. A partial update sets no sum flag.
- R5: On each channel, every `sc_stb` pulse takes one sample of `sc_bit`. A sample equal to the previous one extends the run; a different sample starts a new run of 1. `sc_flag[i]` is set while armed when a run of ones reaches `sc_one_lim` or a run of zeros reaches `sc_zero_lim`. Changes on `sc_bit` without a strobe have no effect. The run count saturates at its maximum value.
- R6: A run limit of 0 disables that direction of short-circuit detection.
- R7: `err_irq` is high exactly while any `oc_flag`, `sc_flag`, `sum_hi_flag` or `sum_lo_flag` bit is set.
- R8: A `stat_clr` pulse clears every flag on the next edge. A flag whose set condition occurs in the same cycle as the clear stays set.
- R9: Detection is disarmed while `run` is low. It is rearmed only by `det_arm` sampled high while `run` is high. While disarmed, no flag is set.
- R10: `res_ready` is all ones, so a result is never stalled. Every flag appears one clock edge after the input that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Channels running; low disarms detection |
| det_arm | input | 1 | Arms detection when `run` is high |
| res_valid | input | NCH | Per-channel result valid |
| res_ready | output | NCH | Per-channel ready, always high |
| res_data | input | NCH*RW | Per-channel unsigned results, channel i in bits [i*RW +: RW] |
| oc_hi_lim | input | NCH*RW | Per-channel upper limits |
| oc_lo_lim | input | NCH*RW | Per-channel lower limits |
| win_lo | input | NCH*RW | Per-channel window lower bounds |
| win_hi | input | NCH*RW | Per-channel window upper bounds |
| sum_grp | input | 3 | Summed channel group select |
| sum_hi_en | input | 1 | Sum upper threshold enable |
| sum_lo_en | input | 1 | Sum lower threshold enable |
| sum_hi_lim | input | RW | Sum upper threshold |
| sum_lo_lim | input | RW | Sum lower threshold |
| sc_stb | input | NCH | Per-channel bit sample strobe |
| sc_bit | input | NCH | Per-channel modulator bit |
| sc_one_lim | input | CW | Run length of ones that flags a short circuit |
| sc_zero_lim | input | CW | Run length of zeros that flags a short circuit |
| stat_clr | input | 1 | Status read-and-clear strobe |
| oc_flag | output | NCH | Per-channel overcurrent flags |
| win_flag | output | NCH | Per-channel window flags |
| sc_flag | output | NCH | Per-channel short-circuit flags |
| sum_hi_flag | output | 1 | Sum above upper threshold |
| sum_lo_flag | output | 1 | Sum below lower threshold |
| err_irq | output | 1 | Level error interrupt |

## Verification
The hardest cases to reach from the ports are a run that crosses its limit exactly on the strobe that completes it, and the same run when strobe-less toggles are mixed in between samples. The bench first starts a fresh run with one opposite-valued strobe and clears the flags. It then sends exactly n equal strobes for each n from 1 to 8, so the expected flag is simply n compared with the limit. A further pass toggles the bit between strobes, and the flag must follow only the strobed samples. The summing path is swept over all eight group codes and a grid of result triples. A partial-valid case confirms that an incomplete update is ignored.

// File: rtl/ocsc_pkg.sv
package ocsc_pkg;

  typedef enum logic [2:0] {
    GRP_ALL = 3'd0,
    GRP_01  = 3'd1,
    GRP_0   = 3'd2,
    GRP_1   = 3'd3,
    GRP_2   = 3'd4
  } grp_e;

  // Channel mask (channels 0..2) selected by the sum group code.
  function automatic logic [2:0] grp_mask(input logic [2:0] sel);
    case (sel)
      GRP_ALL: grp_mask = 3'b111;
      GRP_01:  grp_mask = 3'b011;
      GRP_0:   grp_mask = 3'b001;
      GRP_1:   grp_mask = 3'b010;
      GRP_2:   grp_mask = 3'b100;
      default: grp_mask = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/ocsc_limit_chk.sv
module ocsc_limit_chk #(
  parameter int RW = 18
) (
  input  logic          valid,
  input  logic [RW-1:0] data,
  input  logic [RW-1:0] hi_lim,
  input  logic [RW-1:0] lo_lim,
  input  logic [RW-1:0] w_lo,
  input  logic [RW-1:0] w_hi,
  output logic          over,
  output logic          inwin
);
  always_comb begin
    over  = valid && ((data > hi_lim) || (data < lo_lim));
    inwin = valid && (data >= w_lo) && (data <= w_hi);
  end
endmodule

// File: rtl/ocsc_run_len.sv
module ocsc_run_len #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          bit_in,
  input  logic [CW-1:0] one_lim,
  input  logic [CW-1:0] zero_lim,
  output logic          hit
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] CONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          last_q;
  logic          same;

  always_comb begin
    same  = (bit_in == last_q) && (cnt_q != '0);
    cnt_n = same ? ((cnt_q == CMAX) ? cnt_q : cnt_q + CONE) : CONE;
    if (!stb)
      hit = 1'b0;
    else if (bit_in)
      hit = (one_lim != '0) && (cnt_n >= one_lim);
    else
      hit = (zero_lim != '0) && (cnt_n >= zero_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (stb) begin
      cnt_q  <= cnt_n;
      last_q <= bit_in;
    end
  end
endmodule

// File: rtl/ocsc_sum_chk.sv
module ocsc_sum_chk
  import ocsc_pkg::*;
#(
  parameter int NCH = 3,
  parameter int RW  = 18
) (
  input  logic [NCH-1:0]    valid,
  input  logic [NCH*RW-1:0] data,
  input  logic [2:0]        grp,
  input  logic              hi_en,
  input  logic              lo_en,
  input  logic [RW-1:0]     hi_lim,
  input  logic [RW-1:0]     lo_lim,
  output logic              hit_hi,
  output logic              hit_lo
);
  localparam int NG = 3;
  localparam int SW = RW + 2;

  logic [NG-1:0] mask;
  logic [SW-1:0] acc;
  logic          ready_all;

  always_comb begin
    mask = grp_mask(grp);
    acc  = '0;
    for (int i = 0; i < NG; i++)
      if (mask[i]) acc = acc + SW'(data[i*RW +: RW]);
    ready_all = (mask != '0) && (&(valid[NG-1:0] | ~mask));
    hit_hi = ready_all && hi_en && (acc > SW'(hi_lim));
    hit_lo = ready_all && lo_en && (acc < SW'(lo_lim));
  end
endmodule

// File: rtl/ocsc_guard.sv
module ocsc_guard #(
  parameter int NCH = 3,
  parameter int RW  = 18,
  parameter int CW  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              det_arm,
  input  logic [NCH-1:0]    res_valid,
  output logic [NCH-1:0]    res_ready,
  input  logic [NCH*RW-1:0] res_data,
  input  logic [NCH*RW-1:0] oc_hi_lim,
  input  logic [NCH*RW-1:0] oc_lo_lim,
  input  logic [NCH*RW-1:0] win_lo,
  input  logic [NCH*RW-1:0] win_hi,
  input  logic [2:0]        sum_grp,
  input  logic              sum_hi_en,
  input  logic              sum_lo_en,
  input  logic [RW-1:0]     sum_hi_lim,
  input  logic [RW-1:0]     sum_lo_lim,
  input  logic [NCH-1:0]    sc_stb,
  input  logic [NCH-1:0]    sc_bit,
  input  logic [CW-1:0]     sc_one_lim,
  input  logic [CW-1:0]     sc_zero_lim,
  input  logic              stat_clr,
  output logic [NCH-1:0]    oc_flag,
  output logic [NCH-1:0]    win_flag,
  output logic [NCH-1:0]    sc_flag,
  output logic              sum_hi_flag,
  output logic              sum_lo_flag,
  output logic              err_irq
);
  logic           det_on;
  logic [NCH-1:0] oc_set, win_set, sc_set;
  logic           shi_set, slo_set;

  assign res_ready = '1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ocsc_limit_chk #(.RW(RW)) u_lim (
      .valid  (res_valid[g]),
      .data   (res_data[g*RW +: RW]),
      .hi_lim (oc_hi_lim[g*RW +: RW]),
      .lo_lim (oc_lo_lim[g*RW +: RW]),
      .w_lo   (win_lo[g*RW +: RW]),
      .w_hi   (win_hi[g*RW +: RW]),
      .over   (oc_set[g]),
      .inwin  (win_set[g])
    );
    ocsc_run_len #(.CW(CW)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (sc_stb[g]),
      .bit_in   (sc_bit[g]),
      .one_lim  (sc_one_lim),
      .zero_lim (sc_zero_lim),
      .hit      (sc_set[g])
    );
  end

  ocsc_sum_chk #(.NCH(NCH), .RW(RW)) u_sum (
    .valid  (res_valid),
    .data   (res_data),
    .grp    (sum_grp),
    .hi_en  (sum_hi_en),
    .lo_en  (sum_lo_en),
    .hi_lim (sum_hi_lim),
    .lo_lim (sum_lo_lim),
    .hit_hi (shi_set),
    .hit_lo (slo_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        det_on <= 1'b0;
    else if (!run)     det_on <= 1'b0;
    else if (det_arm)  det_on <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_flag     <= '0;
      win_flag    <= '0;
      sc_flag     <= '0;
      sum_hi_flag <= 1'b0;
      sum_lo_flag <= 1'b0;
    end else begin
      oc_flag     <= (stat_clr ? '0 : oc_flag)     | (det_on ? oc_set  : '0);
      win_flag    <= (stat_clr ? '0 : win_flag)    | (det_on ? win_set : '0);
      sc_flag     <= (stat_clr ? '0 : sc_flag)     | (det_on ? sc_set  : '0);
      sum_hi_flag <= (!stat_clr && sum_hi_flag)    | (det_on && shi_set);
      sum_lo_flag <= (!stat_clr && sum_lo_flag)    | (det_on && slo_set);
    end
  end

  assign err_irq = (|oc_flag) | (|sc_flag) | sum_hi_flag | sum_lo_flag;

endmodule

// File: rtl/ocsc_guard_chk.sv
module ocsc_guard_chk #(
  parameter int NCH = 3,
  parameter int RW  = 18,
  parameter int CW  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              det_on,
  input logic              stat_clr,
  input logic [NCH-1:0]    res_valid,
  input logic [NCH-1:0]    res_ready,
  input logic [NCH*RW-1:0] res_data,
  input logic [NCH*RW-1:0] oc_hi_lim,
  input logic [NCH-1:0]    sc_stb,
  input logic [CW-1:0]     sc_one_lim,
  input logic [CW-1:0]     sc_zero_lim,
  input logic [NCH-1:0]    oc_flag,
  input logic [NCH-1:0]    win_flag,
  input logic [NCH-1:0]    sc_flag,
  input logic              sum_hi_flag,
  input logic              sum_lo_flag,
  input logic              err_irq
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_oc_above_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (det_on && res_valid[g] && (res_data[g*RW +: RW] > oc_hi_lim[g*RW +: RW]))
      |=> oc_flag[g]);

    p_zero_lim_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sc_flag[g]) |-> $past((sc_one_lim != '0) || (sc_zero_lim != '0)));
  end

  p_win_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|win_flag) && !(|oc_flag) && !(|sc_flag) && !sum_hi_flag && !sum_lo_flag)
    |-> !err_irq);

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|oc_flag) || (|sc_flag) || sum_hi_flag || sum_lo_flag) |-> err_irq);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && (res_valid == '0) && (sc_stb == '0))
    |=> (oc_flag == '0 && win_flag == '0 && sc_flag == '0 && !sum_hi_flag && !sum_lo_flag));

  p_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !det_on |=> ((oc_flag & ~$past(oc_flag)) == '0 && (sc_flag & ~$past(sc_flag)) == '0));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready == {NCH{1'b1}});
endmodule

bind ocsc_guard ocsc_guard_chk #(.NCH(NCH), .RW(RW), .CW(CW)) u_chk (.*);

// File: tb/ocsc_guard_bench.sv
module ocsc_guard_bench;
  localparam int NCH = 3;
  localparam int RW  = 8;
  localparam int CW  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, run, det_arm, stat_clr;
  logic [NCH-1:0] res_valid, res_ready, sc_stb, sc_bit;
  logic [NCH*RW-1:0] res_data, oc_hi_lim, oc_lo_lim, win_lo, win_hi;
  logic [2:0] sum_grp;
  logic sum_hi_en, sum_lo_en;
  logic [RW-1:0] sum_hi_lim, sum_lo_lim;
  logic [CW-1:0] sc_one_lim, sc_zero_lim;
  logic [NCH-1:0] oc_flag, win_flag, sc_flag;
  logic sum_hi_flag, sum_lo_flag, err_irq;

  ocsc_guard #(.NCH(NCH), .RW(RW), .CW(CW)) u_ocsc_guard (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear();
    stat_clr = 1'b1; tick(); stat_clr = 1'b0;
  endtask

  task automatic strobe(input int ch, input logic b);
    sc_stb[ch] = 1'b1; sc_bit[ch] = b; tick(); sc_stb[ch] = 1'b0;
  endtask

  function automatic logic [2:0] mask_of(input int s);
    case (s)
      0: return 3'b111;
      1: return 3'b011;
      2: return 3'b001;
      3: return 3'b010;
      4: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  initial begin
    rst_n = 0; run = 0; det_arm = 0; stat_clr = 0;
    res_valid = '0; res_data = '0; sc_stb = '0; sc_bit = '0;
    sum_grp = 3'd0; sum_hi_en = 0; sum_lo_en = 0; sum_hi_lim = '0; sum_lo_lim = '0;
    sc_one_lim = '0; sc_zero_lim = '0;
    for (int c = 0; c < NCH; c++) begin
      oc_hi_lim[c*RW +: RW] = 8'd200; oc_lo_lim[c*RW +: RW] = 8'd40;
      win_lo[c*RW +: RW] = 8'd100;    win_hi[c*RW +: RW] = 8'd120;
    end
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R10 reset flags", int'({oc_flag, win_flag, sc_flag, sum_hi_flag, sum_lo_flag}), 0);
    chk("R7 reset irq", int'(err_irq), 0);
    chk("R10 ready", int'(res_ready), 7);

    // R9: not armed yet
    run = 1; res_valid = '1; res_data = {3{8'd250}}; tick(); res_valid = '0;
    chk("R9 unarmed", int'(oc_flag), 0);
    det_arm = 1; run = 0; tick(); det_arm = 0; run = 1;
    res_valid = '1; tick(); res_valid = '0;
    chk("R9 arm ignored when stopped", int'(oc_flag), 0);
    det_arm = 1; tick(); det_arm = 0;
    res_valid = '1; tick(); res_valid = '0;
    chk("R9 armed", int'(oc_flag), 7);
    chk("R7 irq set", int'(err_irq), 1);
    clear();
    chk("R8 cleared", int'(oc_flag), 0);
    chk("R7 irq drop", int'(err_irq), 0);

    // R1/R2 sweep
    for (int v = 0; v < 256; v++) begin
      logic [2:0] eo, ew;
      int d [3];
      d[0] = v; d[1] = (v + 85) % 256; d[2] = 255 - v;
      for (int c = 0; c < 3; c++) begin
        res_data[c*RW +: RW] = 8'(d[c]);
        eo[c] = (d[c] > 200) || (d[c] < 40);
        ew[c] = (d[c] >= 100) && (d[c] <= 120);
      end
      res_valid = '1; tick(); res_valid = '0;
      chk("R1 oc", int'(oc_flag), int'(eo));
      chk("R2 window", int'(win_flag), int'(ew));
      chk("R7 irq", int'(err_irq), int'(eo != 0));
      clear();
      chk("R8 clear", int'({oc_flag, win_flag}), 0);
    end

    // R8 set wins over clear
    res_data = {3{8'd250}}; res_valid = 3'b001; stat_clr = 1; tick();
    res_valid = '0; stat_clr = 0;
    chk("R8 set wins", int'(oc_flag), 1);
    clear();

    // R3/R4 sum sweep
    for (int c = 0; c < NCH; c++) begin
      oc_hi_lim[c*RW +: RW] = 8'd255; oc_lo_lim[c*RW +: RW] = 8'd0;
    end
    sum_hi_lim = 8'd200; sum_lo_lim = 8'd100; sum_hi_en = 1; sum_lo_en = 1;
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 64; k++) begin
        int vals [4];
        int a, b, cc, sm;
        logic [2:0] m;
        vals[0] = 0; vals[1] = 60; vals[2] = 130; vals[3] = 255;
        a = vals[k % 4]; b = vals[(k / 4) % 4]; cc = vals[k / 16];
        m = mask_of(s);
        sm = (m[0] ? a : 0) + (m[1] ? b : 0) + (m[2] ? cc : 0);
        sum_grp = 3'(s);
        res_data = {8'(cc), 8'(b), 8'(a)};
        res_valid = '1; tick(); res_valid = '0;
        chk("R3 sum high", int'(sum_hi_flag), int'((m != 0) && (sm > 200)));
        chk("R3 sum low", int'(sum_lo_flag), int'((m != 0) && (sm < 100)));
        clear();
      end
    end
    sum_grp = 3'd0; res_data = '0; res_valid = 3'b011; tick(); res_valid = '0;
    chk("R4 partial update", int'(sum_lo_flag), 0);
    sum_grp = 3'd1; res_valid = 3'b011; tick(); res_valid = '0;
    chk("R4 full group", int'(sum_lo_flag), 1);
    clear();
    sum_lo_en = 0; res_valid = '1; tick(); res_valid = '0;
    chk("R3 low disabled", int'(sum_lo_flag), 0);
    clear();

    // R5 run lengths
    sc_one_lim = 4'd3; sc_zero_lim = 4'd5;
    for (int c = 0; c < NCH; c++) begin
      for (int n = 1; n <= 8; n++) begin
        strobe(c, 1'b0); clear();
        for (int j = 0; j < n; j++) strobe(c, 1'b1);
        chk("R5 ones run", int'(sc_flag[c]), int'(n >= 3));
        chk("R7 irq sc", int'(err_irq), int'(n >= 3));
        clear();
        strobe(c, 1'b1); clear();
        for (int j = 0; j < n; j++) strobe(c, 1'b0);
        chk("R5 zeros run", int'(sc_flag[c]), int'(n >= 5));
        clear();
      end
    end
    // R5 bit toggles without strobe do not break the run
    strobe(1, 1'b0); clear();
    strobe(1, 1'b1); strobe(1, 1'b1);
    sc_bit[1] = 1'b0; tick(); tick(); sc_bit[1] = 1'b1; tick();
    chk("R5 no strobe no effect", int'(sc_flag[1]), 0);
    strobe(1, 1'b1);
    chk("R5 run resumed", int'(sc_flag[1]), 1);
    clear();
    // R5 saturation at maximum count
    sc_one_lim = 4'd15;
    strobe(2, 1'b0); clear();
    for (int j = 0; j < 20; j++) strobe(2, 1'b1);
    chk("R5 saturated run", int'(sc_flag[2]), 1);
    clear();
    // R6 zero limits disable
    sc_one_lim = 4'd0; sc_zero_lim = 4'd0;
    for (int j = 0; j < 12; j++) strobe(0, 1'b1);
    for (int j = 0; j < 12; j++) strobe(0, 1'b0);
    chk("R6 zero limits", int'(sc_flag), 0);
    chk("R6 irq quiet", int'(err_irq), 0);

    // R9 stopping disarms
    run = 0; tick(); run = 1;
    res_data = {3{8'd0}}; sum_lo_en = 1; res_valid = '1; tick(); res_valid = '0;
    chk("R9 disarmed after stop", int'(sum_lo_flag), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule